// File: doc/BRIEF.md
# EDID Register Responder

This block is a memory-mapped target that imitates a display-data serial bus controller for a host driver. Instead of moving bytes over a two-wire bus, it answers the driver's register traffic directly from a 128-byte monitor identification store held inside the block. Each transfer is complete the moment it is issued: a read of the data register hands back up to four identification bytes and moves the bus phase on.

The driver sees four 32-bit registers, picked by a 2-bit address. Code 0 is pin select, 1 is command, 2 is status and 3 is data. Writes and reads use separate strobes, and both may fire in the same cycle. Read data is registered and is valid in the cycle after the read strobe. The side effects of a read (the in-use semaphore, pointer advance, phase change) are applied at that same clock edge.

Two input vectors describe each of the NPORT ports: whether a monitor is attached and whether that port is a packetised display port. The current bus phase is output for observation, encoded idle=0, data=1, wait=2. Store byte i holds (37*i + 0x5A) mod 256 for the default parameters.

Top module: `edid_reg_responder`

## Requirements
- R1: After reset, status reads 0x0000_0C00 (ready bit 11 and error bit 10 set, all others clear), the command register reads 0, the data register reads 0 and the phase is idle (0).
- R2: A status read returns the current value and then sets the in-use bit 15. A status write with bit 15 set clears in-use. Every other status bit ignores writes.
- R3: A pin-select write (value in bits 2:0) re-initialises the selection state and returns the phase to idle. Value 0 selects nothing. Value p in 1..NPORT selects port p-1, clears active (bit 9) and sets ready (bit 11) and wait (bit 14). If that port has a monitor that is not a packetised port, the identification data becomes available and error (bit 10) clears; otherwise error is set. Values above NPORT leave status unchanged.
- R4: A command write latches the byte count from bits 24:16, the device address from bits 7:1 and the read direction from bit 0. Only address 0x50 selects the identification device; any other address selects nothing.
- R5: When command bit 26 (index flag) is set, the read pointer is loaded from bits 15:8.
- R6: Cycle codes in bits 27:25 with bit 25 set (1, 3, 5, 7) move the phase to data (1) and set active (bit 9).
- R7: Cycle code 4 (stop) re-initialises the selection, pointer and count, sets the phase to idle and clears active, but only if the previously latched cycle code was nonzero. Otherwise it changes none of these.
- R8: With the read direction latched and remaining = count - pointer > 0, a data read returns n = min(4, remaining) store bytes starting at the pointer. Byte k sits in bits 8k+7:8k, bytes above n keep the previous data word, and the pointer advances by the number of valid bytes taken.
- R9: A data read with remaining of 4 or fewer ends the transfer: the phase goes idle if command bit 27 (stop) is set and to wait (2) otherwise, and the selection, pointer and count are re-initialised.
- R10: A data read with nothing remaining, or with the read direction clear, returns the previous data word. Writes to the data register have no effect.
- R11: A byte taken at pointer position 128 or above, or while no device is selected or no data is available, reads 0x00 and does not advance the pointer.
- R12: A command write with bit 31 set clears interrupt (bit 13) and sets ready. While bit 31 is latched, further command writes with bit 31 set are ignored. A write with bit 31 clear then clears it, sets status to ready plus error (error only if no data is available) and returns the phase to idle. Command bit 30 is always dropped.
- R13: A status read and an in-use-clearing status write in the same cycle return the value before the cycle, and in-use ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register written (0 pin, 1 command, 2 status, 3 data) |
| wr_data | input | 32 | Write value |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read |
| rd_data | output | 32 | Read value, valid the cycle after rd_en |
| mon_present | input | NPORT | Monitor attached, one bit per port |
| mon_is_dp | input | NPORT | Port uses packetised transport, one bit per port |
| bus_phase | output | 2 | Phase: 0 idle, 1 data, 2 wait |

## Verification
The read side and the write side share the status register, so a status read that sets in-use and a status write that clears it can land on the same clock edge. The bench first sets in-use with a plain status read. It then raises both strobes in one cycle, with the write carrying bit 15. The value returned must still show in-use, and a later read must show it clear, which means the write's clear wins over the read's set.

// File: rtl/edid_resp_pkg.sv
// Package: shared encodings for the EDID register responder.
// Assumes a 32-bit register file addressed by a 2-bit code.
package edid_resp_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_WAIT = 2'd2
    } phase_t;

    localparam logic [1:0] RA_PIN    = 2'd0;
    localparam logic [1:0] RA_CMD    = 2'd1;
    localparam logic [1:0] RA_STATUS = 2'd2;
    localparam logic [1:0] RA_DATA   = 2'd3;

    // command field positions (decoded by the driver, so fixed)
    localparam int CB_DIR     = 0;
    localparam int CB_ADDR_LO = 1;
    localparam int CB_IDX_LO  = 8;
    localparam int CB_CNT_LO  = 16;
    localparam int CB_CYC_LO  = 25;
    localparam int CB_INDEX   = 26;
    localparam int CB_STOP    = 27;
    localparam int CB_SWRDY   = 30;
    localparam int CB_CLRINT  = 31;

    localparam logic [2:0] CYC_NONE = 3'd0;
    localparam logic [2:0] CYC_STOP = 3'd4;
endpackage

// File: rtl/edid_store.sv
// Module: edid_store
// Holds the identification bytes as a computed table and offers
// LANES byte-wide read lanes starting at a base pointer.
// Assumes DEPTH is a power of two; lanes past DEPTH read zero.
module edid_store #(
    parameter int DEPTH   = 128,
    parameter int LANES   = 4,
    parameter int PW      = 8,
    parameter int PAT_MUL = 37,
    parameter int PAT_ADD = 90
) (
    input  logic [PW-1:0]            base,
    output logic [LANES-1:0][7:0]    lane_byte,
    output logic [LANES-1:0]         lane_ok
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    // table contents computed from the pattern parameters
    for (genvar k = 0; k < DEPTH; k++) begin : g_fill
        assign mem[k] = 8'((k * PAT_MUL + PAT_ADD) % 256);
    end

    // one read lane per byte of the data word
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PW:0] pos;
        assign pos          = {1'b0, base} + (PW+1)'(i);
        assign lane_ok[i]   = (pos < (PW+1)'(DEPTH));
        assign lane_byte[i] = lane_ok[i] ? mem[pos[AW-1:0]] : 8'h00;
    end
endmodule

// File: rtl/edid_word_pack.sv
// Module: edid_word_pack
// Works out how many bytes a data read takes, merges them little-endian
// into the previous word and reports the pointer advance.
// Assumes count and pointer are unsigned; remaining is computed signed.
module edid_word_pack #(
    parameter int LANES = 4,
    parameter int CW    = 9,
    parameter int PW    = 8
) (
    input  logic [CW-1:0]         count,
    input  logic [PW-1:0]         ptr,
    input  logic                  src_ok,
    input  logic [LANES-1:0][7:0] lane_byte,
    input  logic [LANES-1:0]      lane_ok,
    input  logic [31:0]           prev_word,
    output logic                  has_left,
    output logic                  is_last,
    output logic [31:0]           word,
    output logic [2:0]            adv
);
    localparam int LW = CW + 2;

    logic signed [LW-1:0] left;
    logic [2:0]           take_n;

    // remaining byte count and bytes taken by this read
    always_comb begin
        left     = $signed(LW'(count)) - $signed(LW'(ptr));
        has_left = (left > 0);
        is_last  = (left <= $signed(LW'(LANES)));
        if (left >= $signed(LW'(LANES))) take_n = 3'(LANES);
        else                             take_n = left[2:0];
    end

    // byte merge and advance count
    always_comb begin
        word = prev_word;
        adv  = 3'd0;
        for (int i = 0; i < LANES; i++) begin
            if (3'(i) < take_n) begin
                word[8*i +: 8] = src_ok ? lane_byte[i] : 8'h00;
                if (src_ok && lane_ok[i]) adv = adv + 3'd1;
            end
        end
    end
endmodule

// File: rtl/edid_pin_decode.sv
// Module: edid_pin_decode
// Maps a pin-select code to a port and says whether that port can
// supply identification data (monitor present, not packetised).
// Assumes code p in 1..NPORT selects port p-1.
module edid_pin_decode #(
    parameter int NPORT = 4
) (
    input  logic [2:0]       pin,
    input  logic [NPORT-1:0] present,
    input  logic [NPORT-1:0] is_dp,
    output logic             pin_valid,
    output logic             edid_ok
);
    // range check and per-port lookup
    always_comb begin
        pin_valid = 1'b0;
        edid_ok   = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (pin == 3'(p + 1)) begin
                pin_valid = 1'b1;
                edid_ok   = present[p] && !is_dp[p];
            end
        end
    end
endmodule

// File: rtl/edid_reg_responder.sv
// Module: edid_reg_responder (top)
// Register-level stand-in for a display-data bus controller: decodes
// pin, command, status and data accesses and serves identification
// bytes from a local store. Read effects are applied before write
// effects in the same cycle, so a same-cycle write wins on shared bits.
// Assumes synchronous active-low reset.
module edid_reg_responder
    import edid_resp_pkg::*;
#(
    parameter int NPORT     = 4,
    parameter int DEPTH     = 128,
    parameter int LANES     = 4,
    parameter int PAT_MUL   = 37,
    parameter int PAT_ADD   = 90,
    parameter int EDID_DEV  = 'h50,
    parameter int ST_ACTIVE = 9,
    parameter int ST_ERR    = 10,
    parameter int ST_HWRDY  = 11,
    parameter int ST_INT    = 13,
    parameter int ST_WAIT   = 14,
    parameter int ST_INUSE  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [31:0]      rd_data,
    input  logic [NPORT-1:0] mon_present,
    input  logic [NPORT-1:0] mon_is_dp,
    output logic [1:0]       bus_phase
);
    localparam int CW = 9;
    localparam int PW = 8;

    logic [2:0]    pin_q;
    logic [31:0]   cmd_q;
    logic [31:0]   status_q;
    logic [31:0]   data_q;
    logic [CW-1:0] count_q;
    logic [PW-1:0] ptr_q;
    logic          sel_q;
    logic          avail_q;
    phase_t        phase_q;

    logic [LANES-1:0][7:0] lane_byte;
    logic [LANES-1:0]      lane_ok;
    logic                  has_left, is_last;
    logic [31:0]           packed_word;
    logic [2:0]            adv;
    logic                  pin_valid, pin_edid_ok;
    logic [2:0]            w_cyc;
    logic [6:0]            w_dev;

    assign bus_phase = phase_q;
    assign w_cyc     = wr_data[CB_CYC_LO +: 3];
    assign w_dev     = wr_data[CB_ADDR_LO +: 7];

    edid_store #(
        .DEPTH(DEPTH), .LANES(LANES), .PW(PW),
        .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD)
    ) u_store (
        .base      (ptr_q),
        .lane_byte (lane_byte),
        .lane_ok   (lane_ok)
    );

    edid_word_pack #(.LANES(LANES), .CW(CW), .PW(PW)) u_pack (
        .count     (count_q),
        .ptr       (ptr_q),
        .src_ok    (sel_q && avail_q),
        .lane_byte (lane_byte),
        .lane_ok   (lane_ok),
        .prev_word (data_q),
        .has_left  (has_left),
        .is_last   (is_last),
        .word      (packed_word),
        .adv       (adv)
    );

    edid_pin_decode #(.NPORT(NPORT)) u_pin (
        .pin       (wr_data[2:0]),
        .present   (mon_present),
        .is_dp     (mon_is_dp),
        .pin_valid (pin_valid),
        .edid_ok   (pin_edid_ok)
    );

    // register state: read side effects first, then write effects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q    <= '0;
            cmd_q    <= '0;
            status_q <= '0;
            status_q[ST_HWRDY] <= 1'b1;
            status_q[ST_ERR]   <= 1'b1;
            data_q   <= '0;
            count_q  <= '0;
            ptr_q    <= '0;
            sel_q    <= 1'b0;
            avail_q  <= 1'b0;
            phase_q  <= PH_IDLE;
            rd_data  <= '0;
        end else begin
            if (rd_en) begin
                unique case (rd_addr)
                    RA_PIN:    rd_data <= {29'd0, pin_q};
                    RA_CMD:    rd_data <= cmd_q;
                    RA_STATUS: begin
                        rd_data <= status_q;
                        status_q[ST_INUSE] <= 1'b1;
                    end
                    default: begin
                        if (cmd_q[CB_DIR] && has_left) begin
                            rd_data <= packed_word;
                            data_q  <= packed_word;
                            ptr_q   <= ptr_q + PW'(adv);
                            if (is_last) begin
                                phase_q <= cmd_q[CB_STOP] ? PH_IDLE : PH_WAIT;
                                sel_q   <= 1'b0;
                                avail_q <= 1'b0;
                                ptr_q   <= '0;
                                count_q <= '0;
                            end
                        end else begin
                            rd_data <= data_q;
                        end
                    end
                endcase
            end
            if (wr_en) begin
                unique case (wr_addr)
                    RA_PIN: begin
                        pin_q   <= wr_data[2:0];
                        sel_q   <= 1'b0;
                        avail_q <= 1'b0;
                        ptr_q   <= '0;
                        count_q <= '0;
                        phase_q <= PH_IDLE;
                        if (pin_valid) begin
                            status_q[ST_ACTIVE] <= 1'b0;
                            status_q[ST_HWRDY]  <= 1'b1;
                            status_q[ST_WAIT]   <= 1'b1;
                            if (pin_edid_ok) begin
                                avail_q <= 1'b1;
                                status_q[ST_ERR] <= 1'b0;
                            end else begin
                                status_q[ST_ERR] <= 1'b1;
                            end
                        end
                    end
                    RA_CMD: begin
                        if (cmd_q[CB_CLRINT]) begin
                            if (!wr_data[CB_CLRINT]) begin
                                cmd_q[CB_CLRINT] <= 1'b0;
                                status_q <= '0;
                                status_q[ST_HWRDY] <= 1'b1;
                                status_q[ST_ERR]   <= !avail_q;
                                phase_q <= PH_IDLE;
                            end
                        end else begin
                            if (wr_data[CB_CLRINT]) begin
                                status_q[ST_INT]   <= 1'b0;
                                status_q[ST_HWRDY] <= 1'b1;
                            end
                            count_q <= wr_data[CB_CNT_LO +: CW];
                            if (w_dev == 7'(EDID_DEV)) sel_q <= 1'b1;
                            if (wr_data[CB_INDEX]) ptr_q <= wr_data[CB_IDX_LO +: PW];
                            if (w_cyc == CYC_STOP) begin
                                if (cmd_q[CB_CYC_LO +: 3] != CYC_NONE) begin
                                    sel_q   <= 1'b0;
                                    avail_q <= 1'b0;
                                    ptr_q   <= '0;
                                    count_q <= '0;
                                    phase_q <= PH_IDLE;
                                    status_q[ST_ACTIVE] <= 1'b0;
                                end
                            end else if (w_cyc[0]) begin
                                phase_q <= PH_DATA;
                                status_q[ST_ACTIVE] <= 1'b1;
                            end
                            cmd_q <= wr_data & ~(32'd1 << CB_SWRDY);
                        end
                    end
                    RA_STATUS: begin
                        if (wr_data[ST_INUSE]) status_q[ST_INUSE] <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/edid_reg_responder_chk.sv
// Module: edid_reg_responder_chk
// Temporal checks on the responder, attached by bind below.
// Assumes default status bit positions are passed through parameters.
module edid_reg_responder_chk #(
    parameter int ST_ACTIVE = 9,
    parameter int ST_INUSE  = 15
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        rd_en,
    input logic [1:0]  rd_addr,
    input logic [1:0]  bus_phase,
    input logic [31:0] status_q,
    input logic [31:0] cmd_q
);
    logic st_rd, st_clr, cmd_wr;
    assign st_rd  = rd_en && rd_addr == 2'd2;
    assign st_clr = wr_en && wr_addr == 2'd2 && wr_data[ST_INUSE];
    assign cmd_wr = wr_en && wr_addr == 2'd1 && !cmd_q[31];

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_phase != 2'd3);                                          // R9
    AST_INUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd && !st_clr |=> status_q[ST_INUSE]);                    // R2
    AST_INUSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        st_clr |=> !status_q[ST_INUSE]);                             // R13
    AST_START_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wr_data[25] |=> bus_phase == 2'd1 && status_q[ST_ACTIVE]); // R6
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wr_data[27:25] == 3'd4 && cmd_q[27:25] != 3'd0
        |=> bus_phase == 2'd0 && !status_q[ST_ACTIVE]);              // R7
    AST_SWRDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wr_data[30] |=> !cmd_q[30]);                       // R12
endmodule

bind edid_reg_responder edid_reg_responder_chk #(
    .ST_ACTIVE(ST_ACTIVE), .ST_INUSE(ST_INUSE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .bus_phase(bus_phase), .status_q(status_q), .cmd_q(cmd_q)
);

// File: tb/edid_reg_responder_test.sv
module edid_reg_responder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  mon_present = 4'b0011;
    logic [3:0]  mon_is_dp   = 4'b0010;
    logic [1:0]  bus_phase;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [31:0] last_word, got, w1;

    always #5 clk = ~clk;

    edid_reg_responder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .mon_present(mon_present),
        .mon_is_dp(mon_is_dp), .bus_phase(bus_phase)
    );

    function automatic logic [7:0] pat(int i);
        return (i < 128) ? 8'((i * 37 + 90) % 256) : 8'h00;
    endfunction

    function automatic logic [31:0] pw(int b);
        return {pat(b+3), pat(b+2), pat(b+1), pat(b)};
    endfunction

    function automatic logic [31:0] cmdw(int cyc, int cnt, int idx, int dev, int dir);
        return (32'(cyc) << 25) | (32'(cnt) << 16) | (32'(idx) << 8) | (32'(dev) << 1) | 32'(dir);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1; rd_addr = a;
        @(negedge clk); rd_en = 0; d = rd_data;
    endtask

    task automatic status_is(string req, logic [31:0] exp);
        logic [31:0] v;
        rd(2'd2, v);
        check(req, v, exp);
        wr(2'd2, 32'h0000_8000);
    endtask

    task automatic t_reset();
        check("R1 phase", 32'(bus_phase), 0);
        status_is("R1 status", 32'h0000_0C00);
        rd(2'd1, got); check("R1 cmd", got, 0);
        rd(2'd3, got); check("R1 data", got, 0);
    endtask

    task automatic t_inuse();
        rd(2'd2, got); check("R2 first", got, 32'h0000_0C00);
        rd(2'd2, got); check("R2 inuse set", got, 32'h0000_8C00);
        wr(2'd2, 32'hFFFF_FFFF);
        status_is("R2 clear, ro bits", 32'h0000_0C00);
    endtask

    task automatic t_pin();
        wr(2'd0, 2); status_is("R3 dp port err", 32'h0000_4C00);
        wr(2'd0, 1); status_is("R3 good port", 32'h0000_4800);
        wr(2'd0, 6); status_is("R3 out of range", 32'h0000_4800);
        wr(2'd0, 0); status_is("R3 none", 32'h0000_4800);
        rd(2'd0, got); check("R3 pin readback", got, 0);
    endtask

    task automatic t_full_stop();
        wr(2'd0, 1);
        wr(2'd1, cmdw(7, 8, 0, 'h50, 1));
        check("R6 phase data", 32'(bus_phase), 1);
        status_is("R6 active", 32'h0000_4A00);
        rd(2'd3, got); check("R8 word0", got, pw(0));
        check("R8 mid phase", 32'(bus_phase), 1);
        rd(2'd3, got); check("R8 word1", got, pw(4));
        check("R9 stop to idle", 32'(bus_phase), 0);
        last_word = got;
        rd(2'd3, got); check("R10 empty read", got, last_word);
    endtask

    task automatic t_index_wait();
        wr(2'd0, 1);
        wr(2'd1, cmdw(3, 130, 124, 'h50, 1));
        rd(2'd3, w1); check("R5 index start", w1, pw(124));
        rd(2'd3, got); check("R11 past end merge", got, {w1[31:16], 16'h0});
        check("R9 no stop to wait", 32'(bus_phase), 2);
    endtask

    task automatic t_no_device();
        wr(2'd0, 1);
        wr(2'd1, cmdw(1, 12, 0, 'h51, 1));
        rd(2'd3, got); check("R4 other addr zero", got, 0);
        rd(2'd3, got); check("R11 no advance", got, 0);
        rd(2'd3, got);
        check("R11 still data", 32'(bus_phase), 1);
        wr(2'd1, cmdw(4, 0, 0, 0, 0));
        check("R7 stop idle", 32'(bus_phase), 0);
    endtask

    task automatic t_unavailable();
        wr(2'd0, 2);
        wr(2'd1, cmdw(1, 4, 0, 'h50, 1));
        rd(2'd3, got); check("R11 unavailable zero", got, 0);
        check("R9 ended wait", 32'(bus_phase), 2);
    endtask

    task automatic t_stop_gate();
        wr(2'd0, 1);
        wr(2'd1, cmdw(3, 20, 5, 'h50, 1));
        wr(2'd1, cmdw(0, 20, 0, 'h50, 1));
        wr(2'd1, cmdw(4, 20, 0, 'h50, 1));
        check("R7 gated stop", 32'(bus_phase), 1);
        rd(2'd3, got); check("R7 pointer kept", got, pw(5));
        wr(2'd1, cmdw(4, 20, 0, 'h50, 1));
        check("R7 stop taken", 32'(bus_phase), 0);
        status_is("R7 active clear", 32'h0000_4800);
        last_word = pw(5);
    endtask

    task automatic t_clrint();
        wr(2'd0, 1);
        wr(2'd1, 32'h8000_0000 | cmdw(1, 4, 0, 'h50, 1));
        status_is("R12 set ready", 32'h0000_4A00);
        wr(2'd1, 32'h8000_0000 | cmdw(4, 0, 0, 0, 0));
        check("R12 ignored while latched", 32'(bus_phase), 1);
        wr(2'd1, 0);
        check("R12 idle", 32'(bus_phase), 0);
        status_is("R12 status reset", 32'h0000_0800);
        rd(2'd1, got); check("R12 cmd bit31 cleared", got, cmdw(1, 4, 0, 'h50, 1));
        wr(2'd1, 32'h4000_0000 | cmdw(0, 0, 0, 'h50, 1));
        rd(2'd1, got); check("R12 swrdy dropped", got, cmdw(0, 0, 0, 'h50, 1));
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        rd(2'd2, v);
        @(negedge clk);
        rd_en = 1; rd_addr = 2'd2; wr_en = 1; wr_addr = 2'd2; wr_data = 32'h0000_8000;
        @(negedge clk);
        rd_en = 0; wr_en = 0;
        check("R13 old value", rd_data, v | 32'h0000_8000);
        rd(2'd2, got); check("R13 inuse cleared", got & 32'h0000_8000, 0);
        wr(2'd2, 32'h0000_8000);
    endtask

    task automatic t_data_write();
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd3, got); check("R10 data write ignored", got, last_word);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_inuse();
        t_pin();
        t_full_stop();
        t_index_wait();
        t_no_device();
        t_unavailable();
        t_stop_gate();
        t_clrint();
        t_same_cycle();
        t_data_write();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule